// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a countdown watchdog that sits on a simple 32-bit register port. Software sets a reload value and enables counting through a control byte. While counting is enabled, the counter drops by one on each tick. The tick is either a 1 µs strobe divided down from the system clock or every system clock, chosen by a control bit. Software keeps the watchdog alive by writing one fixed key value to the restart register. Any other value written there does nothing.

When the counter sits at zero and a tick arrives, the watchdog expires. It then emits single-cycle request strobes for a system reset, an interrupt and an external signal, each gated by its own control bit. The reset-domain selector goes out beside the reset strobe. The counter reloads and counting carries on. Each expiry sets a sticky timeout flag. If the secondary-boot bit is set at the moment of expiry, a sticky boot-swap flag is also set, and it drives the chip-select swap output. One write to the clear register clears both flags and restores the normal chip-select mapping.

The sequencer is a three-state machine:
- `ST_STOP` is entered after reset or when counting is disabled. It goes to `ST_COUNT` once the enable bit is 1.
- `ST_COUNT` counts down. It goes to `ST_STOP` when the enable bit is 0, and to `ST_FIRE` on a tick at zero.
- `ST_FIRE` lasts one cycle. It returns to `ST_COUNT`, or to `ST_STOP` if counting is disabled.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, the counter, reload, control and status registers all read 0, and every request output is low.
- R2: Registers sit at these byte offsets:
  - 0x00: counter, read only. Writes to it are ignored.
  - 0x04: reload value.
  - 0x08: restart.
  - 0x0C: control, bits 7:0.
  - 0x10: status, bits 1:0.
  - 0x14: clear.

  Unused offsets read 0.
- R3: A write of exactly 0x00004755 to offset 0x08 loads the counter from the reload register on the next clock edge. Any other value written to 0x08 leaves the counter unchanged.
- R4: Control bit 0 enables counting. While counting, the counter drops by one per tick. With control bit 4 at 1, a tick is one clock in every CLK_PER_US clocks. With bit 4 at 0, every clock is a tick. Counting starts one cycle after the enable bit is seen.
- R5: A tick while the counter is 0 is an expiry. Expiry loads the counter from the reload register, holds a one-cycle fire state, and then counting resumes. A keyed restart in the same cycle takes priority and prevents the expiry.
- R6: In the fire cycle, `rst_req` is high exactly when control bit 1 is set. `rst_domain` always shows control bits 6:5, encoded as 00 SoC, 01 full chip, 10 CPU only.
- R7: In the fire cycle, `irq_pulse` follows control bit 2 and `ext_pulse` follows control bit 3. Each is a single-cycle pulse.
- R8: Writing 0 to the control register stops counting. After that write the counter value does not change.
- R9: An expiry sets status bit 0. If control bit 7 is set at the time of expiry, it also sets status bit 1. `cs_swap` equals status bit 1.
- R10: A write to offset 0x14 with data bit 0 set clears both status bits, and so drops `cs_swap`. With data bit 0 clear, the write has no effect. If an expiry happens in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |
| rst_domain | output | 2 | Reset domain selector |
| irq_pulse | output | 1 | One-cycle interrupt request on expiry |
| ext_pulse | output | 1 | One-cycle external-signal trigger on expiry |
| cs_swap | output | 1 | Chip-select swap flag |

## Verification
Every clock, the bench compares each output port and the read data at the current offset against a behavioural model. A wrong state register or an off-by-one counter therefore shows up within a single cycle, either on the counter read-back or as a fire strobe in the wrong cycle. A status bit that fails to set or fails to clear appears at once on `cs_swap` and on the status read.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } wdt_state_e;

    localparam int OFF_COUNT   = 'h00;
    localparam int OFF_RELOAD  = 'h04;
    localparam int OFF_RESTART = 'h08;
    localparam int OFF_CTRL    = 'h0C;
    localparam int OFF_STATUS  = 'h10;
    localparam int OFF_CLEAR   = 'h14;

    localparam logic [31:0] RESTART_KEY = 32'h0000_4755;

    // control byte bit positions
    localparam int CB_EN     = 0;
    localparam int CB_RST    = 1;
    localparam int CB_IRQ    = 2;
    localparam int CB_EXT    = 3;
    localparam int CB_US     = 4;
    localparam int CB_DOM_LO = 5;
    localparam int CB_DOM_HI = 6;
    localparam int CB_ALT    = 7;
endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_us
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] pre_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pre_q <= '0;
        else if (pre_q == LAST)  pre_q <= '0;
        else                     pre_q <= pre_q + 1'b1;
    end

    assign tick_us = (pre_q == LAST);
endmodule

// File: rtl/wdt_core.sv
module wdt_core
    import wdt_keyed_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             keyed,
    input  logic [CNT_W-1:0] reload,
    output wdt_state_e       st,
    output logic [CNT_W-1:0] cnt,
    output logic             expire,
    output logic             fire
);
    wdt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = keyed ? reload : cnt_q;
        expire  = 1'b0;
        unique case (state_q)
            ST_STOP: begin
                if (en) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!en) begin
                    state_d = ST_STOP;
                end else if (!keyed && tick) begin
                    if (cnt_q == '0) begin
                        expire  = 1'b1;
                        state_d = ST_FIRE;
                        cnt_d   = reload;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
            ST_FIRE: begin
                state_d = en ? ST_COUNT : ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_comb begin
        st   = state_q;
        cnt  = cnt_q;
        fire = (state_q == ST_FIRE);
    end
endmodule

// File: rtl/wdt_status.sv
module wdt_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       expire,
    input  logic       alt_boot,
    input  logic       clr,
    output logic [1:0] stat
);
    logic [1:0] stat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stat_q <= 2'b00;
        else if (expire) stat_q <= stat_q | {alt_boot, 1'b1};
        else if (clr)    stat_q <= 2'b00;
    end

    assign stat = stat_q;
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int CLK_PER_US = 250,
    parameter int CNT_W      = 32,
    parameter int ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              rst_req,
    output logic [1:0]        rst_domain,
    output logic              irq_pulse,
    output logic              ext_pulse,
    output logic              cs_swap
);
    logic [CNT_W-1:0] reload_q;
    logic [7:0]       ctrl_q;
    logic [CNT_W-1:0] cnt_q;
    logic [1:0]       stat_q;
    wdt_state_e       st;
    logic             tick_us, tick, keyed_wr, clr_wr, expire, fire;

    assign keyed_wr = bus_wr && (bus_addr == ADDR_W'(OFF_RESTART)) && (bus_wdata == RESTART_KEY);
    assign clr_wr   = bus_wr && (bus_addr == ADDR_W'(OFF_CLEAR)) && bus_wdata[0];
    assign tick     = ctrl_q[CB_US] ? tick_us : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= '0;
            ctrl_q   <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFF_RELOAD)) reload_q <= bus_wdata[CNT_W-1:0];
            if (bus_addr == ADDR_W'(OFF_CTRL))   ctrl_q   <= bus_wdata[7:0];
        end
    end

    wdt_tick_gen #(.DIV(CLK_PER_US)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us)
    );

    wdt_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[CB_EN]), .tick(tick),
        .keyed(keyed_wr), .reload(reload_q), .st(st), .cnt(cnt_q),
        .expire(expire), .fire(fire)
    );

    wdt_status u_stat (
        .clk(clk), .rst_n(rst_n), .expire(expire), .alt_boot(ctrl_q[CB_ALT]),
        .clr(clr_wr), .stat(stat_q)
    );

    always_comb begin
        rst_req    = fire & ctrl_q[CB_RST];
        irq_pulse  = fire & ctrl_q[CB_IRQ];
        ext_pulse  = fire & ctrl_q[CB_EXT];
        rst_domain = ctrl_q[CB_DOM_HI:CB_DOM_LO];
        cs_swap    = stat_q[1];
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_COUNT):  bus_rdata = 32'(cnt_q);
            ADDR_W'(OFF_RELOAD): bus_rdata = 32'(reload_q);
            ADDR_W'(OFF_CTRL):   bus_rdata = {24'd0, ctrl_q};
            ADDR_W'(OFF_STATUS): bus_rdata = {30'd0, stat_q};
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk
    import wdt_keyed_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input wdt_state_e       st,
    input logic [CNT_W-1:0] cnt_q,
    input logic [1:0]       stat_q,
    input logic             keyed_wr,
    input logic             rst_req,
    input logic             irq_pulse,
    input logic             cs_swap
);
    a_r6_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r7_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    a_r8_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP && !keyed_wr) |=> $stable(cnt_q));

    a_r9_fire_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FIRE) |-> stat_q[0]);

    a_r9_swap_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_swap) |-> (st == ST_FIRE));
endmodule

bind wdt_keyed wdt_keyed_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .st(st), .cnt_q(cnt_q), .stat_q(stat_q),
    .keyed_wr(keyed_wr), .rst_req(rst_req), .irq_pulse(irq_pulse), .cs_swap(cs_swap)
);

// File: tb/tb_wdt_keyed.sv
module tb_wdt_keyed;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, irq_pulse, ext_pulse, cs_swap;
    logic [1:0]  rst_domain;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    wdt_keyed #(.CLK_PER_US(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
        .rst_domain(rst_domain), .irq_pulse(irq_pulse), .ext_pulse(ext_pulse),
        .cs_swap(cs_swap)
    );

    // behavioural reference: 0 stopped, 1 counting, 2 firing
    int          m_state;
    int          m_div;
    logic [31:0] m_cnt, m_reload;
    logic [7:0]  m_ctrl;
    logic [1:0]  m_stat;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_div = 0; m_cnt = 0; m_reload = 0; m_ctrl = 0; m_stat = 0;
        end else begin
            bit tick, keyed, fired;
            tick  = m_ctrl[4] ? (m_div == DIV - 1) : 1'b1;
            m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
            keyed = bus_wr && bus_addr == 5'h08 && bus_wdata == 32'h4755;
            fired = 1'b0;
            if (m_state == 0) begin
                if (keyed) m_cnt = m_reload;
                if (m_ctrl[0]) m_state = 1;
            end else if (m_state == 1) begin
                if (!m_ctrl[0]) begin
                    m_state = 0;
                    if (keyed) m_cnt = m_reload;
                end else if (keyed) begin
                    m_cnt = m_reload;
                end else if (tick) begin
                    if (m_cnt == 0) begin
                        fired = 1'b1; m_state = 2; m_cnt = m_reload;
                        m_stat[0] = 1'b1;
                        if (m_ctrl[7]) m_stat[1] = 1'b1;
                    end else m_cnt = m_cnt - 1;
                end
            end else begin
                if (keyed) m_cnt = m_reload;
                m_state = m_ctrl[0] ? 1 : 0;
            end
            if (!fired && bus_wr && bus_addr == 5'h14 && bus_wdata[0]) m_stat = 2'b00;
            if (bus_wr && bus_addr == 5'h04) m_reload = bus_wdata;
            if (bus_wr && bus_addr == 5'h0C) m_ctrl = bus_wdata[7:0];
        end
    end

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a)
            5'h00: return m_cnt;
            5'h04: return m_reload;
            5'h0C: return {24'd0, m_ctrl};
            5'h10: return {30'd0, m_stat};
            default: return 32'd0;
        endcase
    endfunction

    // per-cycle comparison, sampled 1 ns after the active edge
    always @(posedge clk) begin
        cycles++;
        #1;
        if (rst_n) begin
            bit f;
            f = (m_state == 2);
            check("R5/R6 rst_req", {31'd0, rst_req}, {31'd0, f & m_ctrl[1]});
            check("R6 rst_domain", {30'd0, rst_domain}, {30'd0, m_ctrl[6:5]});
            check("R7 irq_pulse", {31'd0, irq_pulse}, {31'd0, f & m_ctrl[2]});
            check("R7 ext_pulse", {31'd0, ext_pulse}, {31'd0, f & m_ctrl[3]});
            check("R9 cs_swap", {31'd0, cs_swap}, {31'd0, m_stat[1]});
            if (bus_addr == 5'h00)      check("R4 counter", bus_rdata, m_read(bus_addr));
            else if (bus_addr == 5'h10) check("R9 status", bus_rdata, m_read(bus_addr));
            else                        check("R2 readback", bus_rdata, m_read(bus_addr));
        end
    end

    task automatic wr(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 5'h00;
    endtask

    task automatic rd_check(string tag, logic [4:0] a, logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic idle(int n, logic [4:0] a);
        @(negedge clk);
        bus_addr = a;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        fork
            begin : watchdog
                repeat (200000) @(posedge clk);
                miscompares++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
                $finish;
            end
        join_none
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset values
        rd_check("R1 counter", 5'h00, 0);
        rd_check("R1 reload", 5'h04, 0);
        rd_check("R1 ctrl", 5'h0C, 0);
        rd_check("R1 status", 5'h10, 0);
        check("R1 rst_req", {31'd0, rst_req}, 0);

        // R3: key handling, R2: read-only counter
        wr(5'h04, 32'd12);
        wr(5'h08, 32'h4756);
        rd_check("R3 wrong key ignored", 5'h00, 0);
        wr(5'h08, 32'h0001_4755);
        rd_check("R3 wide wrong key ignored", 5'h00, 0);
        wr(5'h08, 32'h4755);
        rd_check("R3 keyed restart", 5'h00, 12);
        wr(5'h00, 32'd99);
        rd_check("R2 counter read-only", 5'h00, 12);
        rd_check("R2 reload readback", 5'h04, 12);
        rd_check("R2 unused offset", 5'h18, 0);

        // R4/R5/R6: per-clock ticks, SoC domain, reset only
        wr(5'h0C, 32'h03);
        idle(40, 5'h00);
        // R7: irq + ext, full-chip domain
        wr(5'h0C, 32'h2F);
        idle(20, 5'h10);
        wr(5'h08, 32'h4755);
        idle(20, 5'h00);
        // R4: 1 us tick, CPU domain, ext only
        wr(5'h0C, 32'h5B);
        idle(150, 5'h00);

        // R8: stop holds counter
        wr(5'h0C, 32'h00);
        @(negedge clk); bus_addr = 5'h00; #1; held = bus_rdata;
        idle(10, 5'h00);
        rd_check("R8 counter held", 5'h00, held);
        rd_check("R9 timeout flag", 5'h10, 1);
        check("R9 no swap", {31'd0, cs_swap}, 0);

        // R10: clear
        wr(5'h14, 32'h0);
        rd_check("R10 no-op clear", 5'h10, 1);
        wr(5'h14, 32'h1);
        rd_check("R10 clear", 5'h10, 0);

        // R9: secondary boot swap
        wr(5'h04, 32'd5);
        wr(5'h0C, 32'h85);
        idle(30, 5'h10);
        rd_check("R9 swap status", 5'h10, 3);
        check("R9 cs_swap set", {31'd0, cs_swap}, 1);
        wr(5'h0C, 32'h00);
        wr(5'h14, 32'h0);
        check("R10 swap kept", {31'd0, cs_swap}, 1);
        wr(5'h14, 32'h1);
        @(negedge clk);
        check("R10 swap cleared", {31'd0, cs_swap}, 0);

        // R10: clear colliding with back-to-back expiries
        wr(5'h04, 32'd0);
        wr(5'h0C, 32'h83);
        for (int i = 0; i < 12; i++) wr(5'h14, 32'h1);
        idle(6, 5'h10);
        wr(5'h0C, 32'h00);
        idle(8, 5'h10);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule